// File: doc/BRIEF.md
# NAND Flash Host Front-End

This block connects a processor register bus to one 8-bit NAND flash device. Software programs a control register and then writes command bytes, address bytes, data bytes and read requests into separate registers. Each such write becomes one entry in a small write buffer. A cycle engine drains the buffer in order and turns each entry into one flash bus cycle: a command latch cycle, an address latch cycle, a plain data write, or a read strobe. The write strobe and the read strobe stay low for a number of clock cycles that software programs.

Reads are split. Software writes any value to the read-request register, waits for the read-ready interrupt flag, and then fetches the byte from the read-data register. The ready/busy pin is synchronised and shown in the status register. Its rising edge sets a sticky flag. The engine starts no flash cycle while the device reports busy.

Page start bits arm a byte counter that marks when a full page of data or read cycles has been issued. Error correction itself is not in this block. A reset register only clears the byte counter and sends a one-cycle clear strobe to outside error-correction logic.

The register interface has no back-pressure. Every bus write is taken in the cycle it is presented, and a bus read returns its data one cycle later. Flow control is left to software: it must poll the buffer-full status bit before each queued write. A queued write that arrives while the buffer is full is dropped and flagged.

Top module: `nand_host_front`

## Requirements
- R1: After reset the strobes are high, CLE, ALE and chip enable are inactive (chip enable high), the interrupt flags read 0, the control register reads 0, and the status register (offset 1) reads 0x0011 while the ready/busy pin is high.
- R2: A write to the command register (offset 3) produces exactly one write-strobe pulse, with CLE high, ALE low and the written byte on the data pins.
- R3: A write to the address register (offset 4) produces one write-strobe pulse with ALE high, CLE low and the byte on the data pins.
- R4: A write to the data register (offset 5) produces one write-strobe pulse with CLE and ALE both low and the byte on the data pins.
- R5: The write strobe stays low for wr_dly+1 clock cycles and the read strobe for rd_dly+1 cycles. The control register (offset 0) has bit 0 = page size (0: 256 bytes, 1: 512 bytes), bit 1 = bus width, bits 7:4 = rd_dly and bits 11:8 = wr_dly, and it reads back as written.
- R6: A write of any value to the read-request register (offset 6) produces one read-strobe cycle. The byte seen on the data input at the end of the strobe appears in the read-data register (offset 7), and interrupt flag bit 3 is set.
- R7: Buffered cycles reach the flash in the order they were written. Status bit 1 is 1 while 4 entries wait, and status bit 4 is 1 while none wait.
- R8: A queued write that arrives while the buffer is full is dropped, never reaches the flash, and sets interrupt flag bit 1.
- R9: Interrupt flag bit 2 is set when the buffer goes from full to not full.
- R10: Writing the interrupt register (offset 2) clears each flag whose bit is written 1 and leaves every other flag unchanged.
- R11: Status bit 0 follows the synchronised ready/busy pin. Its rising edge sets interrupt flag bit 0. No strobe starts while the synchronised pin is low.
- R12: Writing bit 1 of the page register (offset 9) sets status bit 2. The bit clears when the page-size count of data cycles has completed, and interrupt flag bit 4 is set at that moment.
- R13: Writing bit 0 of the page register sets status bit 3. The bit clears when the page-size count of read cycles has completed.
- R14: Writing 1 to bit 0 of the reset register (offset 8) drives the error-correction clear output high for exactly one cycle and restarts the page byte count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data returns on the next cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | OR of all interrupt flags |
| ecc_clr | output | 1 | One-cycle clear strobe for external error-correction logic |
| nand_ce_n | output | 1 | Chip enable, low while a flash cycle runs |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_o | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data from the flash |
| nand_rb | input | 1 | Ready/busy pin, high when ready |

## Verification
The hardest state to reach from the ports is a completely full buffer. With a ready device the engine empties the buffer about as fast as the bus can fill it. The stimulus therefore pulls the ready/busy pin low first, which freezes the engine. It then queues four commands and a fifth that must be dropped, and releases the pin. This one sequence shows the overflow flag, the edge flag, the not-busy flag, the dropped byte and the strobe order together. The page-completion boundary gets the same care: a counter reset partway through a page must shift the completion point to exactly the page size after the reset.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_READ = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e  kind;
    logic [7:0] data;
  } wb_entry_t;

  // register offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_IRQ  = 2;
  localparam int OFF_CMD  = 3;
  localparam int OFF_ADDR = 4;
  localparam int OFF_WDAT = 5;
  localparam int OFF_RREQ = 6;
  localparam int OFF_RDAT = 7;
  localparam int OFF_RST  = 8;
  localparam int OFF_PAGE = 9;

  // interrupt flag positions
  localparam int IRQ_NBUSY = 0;
  localparam int IRQ_OVF   = 1;
  localparam int IRQ_EDGE  = 2;
  localparam int IRQ_RDRDY = 3;
  localparam int IRQ_WDONE = 4;
  localparam int IRQ_N     = 5;

  localparam int CTRL_RD_LSB = 4;
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_wbuf.sv
module nfc_wbuf import nfc_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_ent,
  input  logic      pop,
  output wb_entry_t head_ent,
  output logic      full,
  output logic      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wb_entry_t         slot_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign head_ent = slot_q[rp_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot_q[g] <= '0;
      else if (push && wp_q == PW'(g))        slot_q[g] <= push_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/nfc_cycle_eng.sv
module nfc_cycle_eng import nfc_pkg::*; #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  wb_entry_t        ent,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [DLY_W-1:0] rd_dly,
  input  logic [7:0]       dq_i,
  output logic             idle,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  output logic             done,
  output cyc_kind_e        done_kind,
  output logic [7:0]       rd_byte
);
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} eng_st_e;

  eng_st_e          st_q;
  cyc_kind_e        kind_q;
  logic [7:0]       byte_q;
  logic [DLY_W-1:0] cnt_q;
  logic             is_rd;

  assign is_rd = (kind_q == CYC_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= CYC_CMD;
      byte_q  <= '0;
      cnt_q   <= '0;
      rd_byte <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          kind_q <= ent.kind;
          byte_q <= ent.data;
          cnt_q  <= (ent.kind == CYC_READ) ? rd_dly : wr_dly;
          st_q   <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            st_q <= ST_HOLD;
            if (is_rd) rd_byte <= dq_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign ce_n      = idle;
  assign cle       = !idle && (kind_q == CYC_CMD);
  assign ale       = !idle && (kind_q == CYC_ADDR);
  assign we_n      = !((st_q == ST_STROBE) && !is_rd);
  assign re_n      = !((st_q == ST_STROBE) && is_rd);
  assign dq_o      = byte_q;
  assign dq_oe     = !idle && !is_rd;
  assign done      = (st_q == ST_STROBE) && (cnt_q == '0);
  assign done_kind = kind_q;
endmodule

// File: rtl/nand_host_front.sv
module nand_host_front import nfc_pkg::*; #(
  parameter int BUS_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int DLY_W       = 4,
  parameter int WB_DEPTH    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_SMALL  = 256,
  parameter int PAGE_LARGE  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              ecc_clr,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb
);
  localparam int CNT_W     = $clog2(PAGE_LARGE);
  localparam int WR_LSB    = CTRL_RD_LSB + DLY_W;
  localparam int CTRL_TOP  = WR_LSB + DLY_W;

  // control register
  logic             page_sel_q, width_sel_q;
  logic [DLY_W-1:0] rd_dly_q, wr_dly_q;

  // datapath wiring
  logic             rb_sync, rb_sync_q;
  logic             buf_full, buf_empty, full_q;
  logic             push_try, push, pop, eng_idle;
  wb_entry_t        push_ent, head_ent;
  logic             cyc_done;
  cyc_kind_e        cyc_kind;
  logic [7:0]       rd_byte;

  logic [IRQ_N-1:0] irq_q, irq_set, irq_clr;
  logic             pg_wr_q, pg_rd_q;
  logic [CNT_W-1:0] byte_cnt_q, page_last;
  logic             wr_page_done, rd_page_done, cnt_clear, cnt_step;

  logic wr_hit_ctrl, wr_hit_irq, wr_hit_rst, wr_hit_page;
  assign wr_hit_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_hit_irq  = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ));
  assign wr_hit_rst  = bus_wr && (bus_addr == ADDR_W'(OFF_RST));
  assign wr_hit_page = bus_wr && (bus_addr == ADDR_W'(OFF_PAGE));

  // queued register decode
  always_comb begin
    push_try      = bus_wr;
    push_ent.data = bus_wdata[7:0];
    push_ent.kind = CYC_CMD;
    case (int'(bus_addr))
      OFF_CMD:  push_ent.kind = CYC_CMD;
      OFF_ADDR: push_ent.kind = CYC_ADDR;
      OFF_WDAT: push_ent.kind = CYC_DATA;
      OFF_RREQ: push_ent.kind = CYC_READ;
      default:  push_try      = 1'b0;
    endcase
  end

  assign push = push_try && !buf_full;
  assign pop  = !buf_empty && eng_idle && rb_sync;

  nfc_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .async_i(nand_rb), .sync_o(rb_sync)
  );

  nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent),
    .pop(pop), .head_ent(head_ent), .full(buf_full), .empty(buf_empty)
  );

  nfc_cycle_eng #(.DLY_W(DLY_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(pop), .ent(head_ent),
    .wr_dly(wr_dly_q), .rd_dly(rd_dly_q), .dq_i(nand_dq_i),
    .idle(eng_idle), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .done(cyc_done), .done_kind(cyc_kind), .rd_byte(rd_byte)
  );

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_sel_q  <= 1'b0;
      width_sel_q <= 1'b0;
      rd_dly_q    <= '0;
      wr_dly_q    <= '0;
    end else if (wr_hit_ctrl) begin
      page_sel_q  <= bus_wdata[0];
      width_sel_q <= bus_wdata[1];
      rd_dly_q    <= bus_wdata[CTRL_RD_LSB +: DLY_W];
      wr_dly_q    <= bus_wdata[WR_LSB +: DLY_W];
    end
  end

  // page byte counting
  assign page_last    = page_sel_q ? CNT_W'(PAGE_LARGE - 1) : CNT_W'(PAGE_SMALL - 1);
  assign wr_page_done = pg_wr_q && cyc_done && (cyc_kind == CYC_DATA) && (byte_cnt_q == page_last);
  assign rd_page_done = pg_rd_q && cyc_done && (cyc_kind == CYC_READ) && (byte_cnt_q == page_last);
  assign cnt_clear    = (wr_hit_rst && bus_wdata[0]) || (wr_hit_page && |bus_wdata[1:0]);
  assign cnt_step     = cyc_done && (cyc_kind == CYC_DATA || cyc_kind == CYC_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt_q <= '0;
      pg_wr_q    <= 1'b0;
      pg_rd_q    <= 1'b0;
      ecc_clr    <= 1'b0;
    end else begin
      ecc_clr <= wr_hit_rst && bus_wdata[0];
      if (cnt_clear)                          byte_cnt_q <= '0;
      else if (wr_page_done || rd_page_done)  byte_cnt_q <= '0;
      else if (cnt_step)                      byte_cnt_q <= byte_cnt_q + 1'b1;
      if (wr_hit_page && bus_wdata[1]) pg_wr_q <= 1'b1;
      else if (wr_page_done)           pg_wr_q <= 1'b0;
      if (wr_hit_page && bus_wdata[0]) pg_rd_q <= 1'b1;
      else if (rd_page_done)           pg_rd_q <= 1'b0;
    end
  end

  // sticky interrupt flags, set wins over clear
  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_NBUSY] = rb_sync && !rb_sync_q;
    irq_set[IRQ_OVF]   = push_try && buf_full;
    irq_set[IRQ_EDGE]  = full_q && !buf_full;
    irq_set[IRQ_RDRDY] = cyc_done && (cyc_kind == CYC_READ);
    irq_set[IRQ_WDONE] = wr_page_done;
    irq_clr            = wr_hit_irq ? bus_wdata[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      rb_sync_q <= 1'b1;
      full_q    <= 1'b0;
    end else begin
      irq_q     <= (irq_q & ~irq_clr) | irq_set;
      rb_sync_q <= rb_sync;
      full_q    <= buf_full;
    end
  end

  assign irq = |irq_q;

  // register read-back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (int'(bus_addr))
        OFF_CTRL: bus_rdata[CTRL_TOP-1:0] <= {wr_dly_q, rd_dly_q, 2'b00, width_sel_q, page_sel_q};
        OFF_STAT: bus_rdata[4:0] <= {buf_empty, pg_rd_q, pg_wr_q, buf_full, rb_sync};
        OFF_IRQ:  bus_rdata[IRQ_N-1:0] <= irq_q;
        OFF_RDAT: bus_rdata[7:0] <= rd_byte;
        default:  bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[BUS_W-1:CTRL_TOP] ^ ^bus_wdata[3:2];
endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk #(
  parameter int DLY_W = 4,
  parameter int IRQ_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we_n,
  input logic             re_n,
  input logic             cle,
  input logic             ale,
  input logic             rb_ok,
  input logic [DLY_W-1:0] wr_dly,
  input logic [DLY_W-1:0] rd_dly,
  input logic             buf_full,
  input logic             buf_empty,
  input logic             push_try,
  input logic [IRQ_W-1:0] irq_flags,
  input logic             pg_wr_pend
);
  logic [DLY_W:0] we_lo, re_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo <= '0;
      re_lo <= '0;
    end else begin
      we_lo <= we_n ? '0 : we_lo + 1'b1;
      re_lo <= re_n ? '0 : re_lo + 1'b1;
    end
  end

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo == {1'b0, wr_dly} + 1'b1));
  // R5
  re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> (re_lo == {1'b0, rd_dly} + 1'b1));
  // R11
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> $past(rb_ok));
  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && buf_full) |=> irq_flags[1]);
  // R9
  edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |=> irq_flags[2]);
  // R6
  read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> irq_flags[3]);
  // R12
  page_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_wr_pend) |-> irq_flags[4]);
  // R7
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));
  // R2
  latch_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale) |-> re_n);
endmodule

bind nand_host_front nfc_front_chk #(.DLY_W(DLY_W), .IRQ_W(nfc_pkg::IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n),
  .cle(nand_cle), .ale(nand_ale), .rb_ok(rb_sync),
  .wr_dly(wr_dly_q), .rd_dly(rd_dly_q), .buf_full(buf_full),
  .buf_empty(buf_empty), .push_try(push_try), .irq_flags(irq_q),
  .pg_wr_pend(pg_wr_q)
);

// File: tb/tb_nand_host_front.sv
module tb_nand_host_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, ecc_clr, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  model_val = 8'h5A;
  logic        nand_rb = 1'b1;

  int checks = 0, fails = 0;
  int mon_cnt = 0;
  logic mon_cle, mon_ale;
  logic [7:0] mon_dq;
  logic [7:0] mon_log [16];
  int we_low = 0, re_low = 0, we_w = 0, re_w = 0, ecc_pulses = 0;

  always #4 clk = ~clk;

  nand_host_front dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ecc_clr(ecc_clr),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(model_val), .nand_rb(nand_rb)
  );

  // flash-side monitor and read model
  always @(posedge nand_we_n) if (rst_n) begin
    mon_cle = nand_cle; mon_ale = nand_ale; mon_dq = nand_dq_o;
    mon_log[mon_cnt % 16] = nand_dq_o;
    mon_cnt++;
  end
  always @(posedge nand_re_n) if (rst_n) model_val = model_val + 8'h13;

  always @(posedge clk) begin
    if (!nand_we_n) we_low++; else if (we_low != 0) begin we_w = we_low; we_low = 0; end
    if (!nand_re_n) re_low++; else if (re_low != 0) begin re_w = re_low; re_low = 0; end
    if (ecc_clr) ecc_pulses++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic push(input logic [3:0] a, input logic [7:0] d);
    logic [15:0] s;
    rd(4'd1, s);
    while (s[1]) rd(4'd1, s);
    wr(a, {8'h00, d});
  endtask

  task automatic drain();
    logic [15:0] s;
    rd(4'd1, s);
    while (!s[4]) rd(4'd1, s);
    repeat (20) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // kind(2) byte(8): 0 cmd, 1 addr, 2 data, 3 read request
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'h90}, {2'd1, 8'h00}, {2'd3, 8'h00}, {2'd0, 8'h80},
    {2'd1, 8'h3C}, {2'd2, 8'hA5}, {2'd2, 8'h5A}, {2'd3, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    logic [7:0] exp_rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pins", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_ce_n}, 5'b11001);
    rd(4'd1, v); check("R1 status", v, 16'h0011);
    rd(4'd2, v); check("R1 irq", v, 16'h0000);
    rd(4'd0, v); check("R1 ctrl", v, 16'h0000);

    // R5 control readback: wr_dly 2, rd_dly 3, page 0
    wr(4'd0, 16'h0232);
    rd(4'd0, v); check("R5 ctrl readback", v, 16'h0232);

    // vector table walk (R2 R3 R4 R6 R5)
    for (int i = 0; i < 8; i++) begin
      base = mon_cnt;
      exp_rd = model_val;
      wr(4'd3 + {2'b00, VEC[i][9:8]}, {8'h00, VEC[i][7:0]});
      drain();
      if (VEC[i][9:8] == 2'd3) begin
        rd(4'd7, v); check("R6 read data", v, {8'h00, exp_rd});
        rd(4'd2, v); check("R6 ready flag", v[3], 1'b1);
        check("R5 re width", re_w, 4);
        wr(4'd2, 16'h0008);
      end else begin
        check(VEC[i][9:8] == 2'd0 ? "R2 cycle" : (VEC[i][9:8] == 2'd1 ? "R3 cycle" : "R4 cycle"),
              {mon_cnt - base, 6'b0, mon_cle, mon_ale, mon_dq},
              {32'd1, 6'b0, VEC[i][9:8] == 2'd0, VEC[i][9:8] == 2'd1, VEC[i][7:0]});
        check("R5 we width", we_w, 3);
      end
    end

    // R5 extremes: wr_dly 0, rd_dly 15
    wr(4'd0, 16'h00F0);
    wr(4'd3, 16'h00FF); drain(); check("R5 we width min", we_w, 1);
    wr(4'd6, 16'h0000); drain(); check("R5 re width max", re_w, 16);
    wr(4'd2, 16'h001F);

    // R7 R8 R9 R11: freeze engine with busy device, fill and overflow
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd1, v); check("R11 busy status", v[0], 1'b0);
    base = mon_cnt;
    wr(4'd3, 16'h0011); wr(4'd3, 16'h0022); wr(4'd3, 16'h0033); wr(4'd3, 16'h0044);
    repeat (6) @(negedge clk);
    check("R11 no strobe while busy", mon_cnt - base, 0);
    rd(4'd1, v); check("R7 full status", {v[4], v[1]}, 2'b01);
    rd(4'd2, v); check("R8 no overflow yet", v[1], 1'b0);
    wr(4'd3, 16'h0055);
    rd(4'd2, v); check("R8 overflow flag", v[1], 1'b1);
    check("R9 no edge while full", v[2], 1'b0);
    nand_rb = 1'b1;
    drain();
    check("R8 dropped write", mon_cnt - base, 4);
    check("R7 order", {mon_log[base % 16], mon_log[(base+1) % 16], mon_log[(base+2) % 16], mon_log[(base+3) % 16]},
          32'h11223344);
    rd(4'd2, v); check("R11 not-busy flag", v[0], 1'b1);
    check("R9 edge flag", v[2], 1'b1);
    check("R9 irq pin", irq, 1'b1);

    // R10 write-one-to-clear
    wr(4'd2, 16'h0002);
    rd(4'd2, v); check("R10 clear one bit", v, 16'h0005);
    wr(4'd2, 16'h0000);
    rd(4'd2, v); check("R10 zero has no effect", v, 16'h0005);
    wr(4'd2, 16'h001F);

    // R12 R14: page write of 256 with counter reset partway
    wr(4'd9, 16'h0002);
    rd(4'd1, v); check("R12 pending set", v[2], 1'b1);
    for (int i = 0; i < 10; i++) push(4'd5, 8'(i));
    drain();
    base = ecc_pulses;
    wr(4'd8, 16'h0001);
    repeat (2) @(negedge clk);
    check("R14 single clear pulse", ecc_pulses - base, 1);
    for (int i = 0; i < 255; i++) push(4'd5, 8'(i));
    drain();
    rd(4'd1, v); check("R14 count restarted", v[2], 1'b1);
    rd(4'd2, v); check("R12 no done early", v[4], 1'b0);
    push(4'd5, 8'hEE);
    drain();
    rd(4'd1, v); check("R12 pending cleared", v[2], 1'b0);
    rd(4'd2, v); check("R12 done flag", v[4], 1'b1);

    // R13 page read of 512
    wr(4'd0, 16'h0001);
    wr(4'd9, 16'h0001);
    rd(4'd1, v); check("R13 pending set", v[3], 1'b1);
    for (int i = 0; i < 511; i++) push(4'd6, 8'h00);
    drain();
    rd(4'd1, v); check("R13 pending at 511", v[3], 1'b1);
    exp_rd = model_val;
    push(4'd6, 8'h00);
    drain();
    rd(4'd1, v); check("R13 pending cleared", v[3], 1'b0);
    rd(4'd7, v); check("R6 last page byte", v, {8'h00, exp_rd});

    report();
    $finish;
  end
endmodule